// File: doc/BRIEF.md
# Stereo I2S Receive Deserializer

This block turns a two-channel serial audio stream into 32-bit parallel words and queues them for a downstream reader. The bit clock and word-select lines come from a clock generator elsewhere on the chip. They reach the block as a single-cycle `bit_tick` strobe, one per rising bit-clock edge, together with the `ws_in` and `sd_in` levels sampled at that strobe. Word-select low marks a left-channel slot and high marks a right-channel slot. Each slot is 32 bit clocks long and carries a 24-bit significant sample inside a 32-bit word.

Three configuration inputs set how the stream is read:
- `right_first` chooses which channel opens each stored pair.
- `msb_right` stores every word bit-reversed.
- `msb_shift` delays the first data bit of a slot by one bit clock after the word-select change.

Accepted words go into a 128-entry first-in first-out buffer. A counter raises a one-cycle end-of-block pulse each time a programmable number of words has been stored. Three sticky interrupt flags report the buffer becoming full, the buffer becoming empty, and a word being taken in. Each flag has its own enable and a write-one clear.

Top module: `i2s_rx_core`

## Requirements
- R1: With `rst_n` low, or on the clock after `soft_rst` is high, the buffer is empty (`rd_valid`=0) and `int_flags`, `overflow` and `eob` are 0.
- R2: A word is stored only once a complete 32-tick slot has been captured. By default the first bit of a slot is the one sampled on the tick at which `ws_in` changes, and it lands in bit 31. A slot that is cut short, and the slot in progress when `rx_start` rises, are discarded. A stored word appears on `rd_data`/`rd_valid` two clocks after the tick that closes its slot.
- R3: With `msb_shift`=1, the first data bit of a slot is sampled on the tick after the `ws_in` change. The bit sampled on the change tick becomes bit 0 of the previous slot's word.
- R4: The first word stored after `rx_start` rises is from the left channel (`ws_in`=0) when `right_first`=0, and from the right channel (`ws_in`=1) when `right_first`=1. Words of the other channel that arrive earlier are dropped. After that, channels alternate.
- R5: With `msb_right`=1, each stored word is the bit-reverse of the word that `msb_right`=0 would have stored.
- R6: The buffer is first-in first-out with 128 entries. `rd_valid` is high whenever it holds a word, `rd_data` shows the oldest word, and `rd_en` with `rd_valid` high removes that word.
- R7: A word that arrives while the buffer holds 128 entries is dropped, the contents are unchanged, and `overflow` goes to 1 and stays there until reset.
- R8: `eob` pulses for one clock each time the number of stored words since reset reaches a multiple of `eob_len`. An `eob_len` of 0 selects 128.
- R9: Flag bit 0 sets when the buffer becomes full. Bit 1 sets when a read leaves the buffer empty. Bit 2 sets on every stored word. A 1 in `int_clr` clears the matching bit, and a set in the same clock wins.
- R10: `irq` is high exactly when some flag bit is set whose `int_ena` bit is also set.
- R11: While `rx_start` is 0, no word is stored and the buffer contents stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of the receiver, buffer and flags |
| rx_start | input | 1 | Enables reception |
| right_first | input | 1 | Right channel opens each stored pair |
| msb_right | input | 1 | Store words bit-reversed |
| msb_shift | input | 1 | First data bit one tick after the word-select change |
| eob_len | input | 16 | Words per end-of-block pulse (0 selects 128) |
| bit_tick | input | 1 | One-cycle strobe on each rising bit-clock edge |
| ws_in | input | 1 | Word-select level (0 left, 1 right) |
| sd_in | input | 1 | Serial data level |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest stored word |
| rd_valid | output | 1 | Buffer holds at least one word |
| int_ena | input | 3 | Interrupt enables (0 full, 1 empty, 2 take) |
| int_clr | input | 3 | Write-one clear of the flags |
| int_flags | output | 3 | Sticky flags (0 full, 1 empty, 2 take) |
| irq | output | 1 | Any enabled flag set |
| eob | output | 1 | End-of-block pulse |
| overflow | output | 1 | Sticky dropped-word indication |

## Verification
The hardest state to reach from the ports is a completely full buffer that keeps receiving slots. Only there do the drop path, the sticky overflow bit, the full flag and the default end-of-block length all come into play. The bench reaches it by streaming 132 slots with no reads and then draining all 128 entries in order. Channel alignment is reached by starting each stream on a left slot, which the right-first setting must discard. The delayed-MSB mode is exercised by sending each word's last bit on the word-select change tick.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  localparam int IRQ_N     = 3;
  localparam int IRQ_FULL  = 0;
  localparam int IRQ_EMPTY = 1;
  localparam int IRQ_TAKE  = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // Words per end-of-block pulse; zero selects the default length.
  function automatic int unsigned eob_goal(input int unsigned len, input int unsigned dflt);
    return (len == 0) ? dflt : len;
  endfunction

  // Occupancy after one clock of simultaneous write and read.
  function automatic int unsigned level_next(input int unsigned lvl, input logic wr, input logic rd);
    return lvl + (wr ? 1 : 0) - (rd ? 1 : 0);
  endfunction

endpackage

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
  import i2s_rx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              right_first,
  input  logic              msb_shift,
  input  logic              msb_right,
  input  logic              bit_tick,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data,
  output logic              slot_bound
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              ws_q;
  logic              edge_d;
  logic              synced;
  logic              aligned;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  chan_e             slot_ch;

  logic              ws_change;
  logic              slot_full;
  logic              keep_word;
  chan_e             lead_ch;
  logic [WORD_W-1:0] rev_word;
  logic [WORD_W-1:0] out_word;

  // Bit-reversed view of the capture register.
  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_rev
    assign rev_word[gi] = shreg[WORD_W-1-gi];
  end

  assign ws_change  = (ws_in != ws_q);
  assign slot_bound = bit_tick && (msb_shift ? edge_d : ws_change);
  assign lead_ch    = right_first ? CH_RIGHT : CH_LEFT;
  assign slot_full  = synced && (bit_cnt == CNT_W'(WORD_W));
  assign keep_word  = slot_full && (aligned || (slot_ch == lead_ch));
  assign out_word   = msb_right ? rev_word : shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= 1'b0;
      edge_d    <= 1'b0;
      synced    <= 1'b0;
      aligned   <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      slot_ch   <= CH_LEFT;
      word_vld  <= 1'b0;
      word_data <= '0;
    end else if (clr) begin
      ws_q      <= 1'b0;
      edge_d    <= 1'b0;
      synced    <= 1'b0;
      aligned   <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      slot_ch   <= CH_LEFT;
      word_vld  <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!run) begin
        ws_q    <= ws_in;
        edge_d  <= 1'b0;
        synced  <= 1'b0;
        aligned <= 1'b0;
        bit_cnt <= '0;
      end else if (bit_tick) begin
        ws_q   <= ws_in;
        edge_d <= ws_change;
        if (slot_bound) begin
          if (keep_word) begin
            word_vld  <= 1'b1;
            word_data <= out_word;
            aligned   <= 1'b1;
          end
          synced  <= 1'b1;
          bit_cnt <= CNT_W'(1);
          shreg   <= {{(WORD_W-1){1'b0}}, sd_in};
          slot_ch <= chan_e'(ws_in);
        end else if (bit_cnt < CNT_W'(WORD_W)) begin
          shreg   <= {shreg[WORD_W-2:0], sd_in};
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_req,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       rd_req,
  output logic [WORD_W-1:0]          rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       wr_ok,
  output logic                       rd_ok,
  output logic                       drop
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     rptr;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign wr_ok   = wr_req && !full;
  assign rd_ok   = rd_req && !empty;
  assign drop    = wr_req && full;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
      level <= CW'(i2s_rx_pkg::level_next(int'(level), wr_ok, rd_ok));
    end
  end

endmodule

// File: rtl/i2s_rx_events.sv
module i2s_rx_events
  import i2s_rx_pkg::*;
#(
  parameter int EOB_W       = 16,
  parameter int EOB_DEFAULT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [IRQ_N-1:0] ev,
  input  logic [IRQ_N-1:0] int_ena,
  input  logic [IRQ_N-1:0] int_clr,
  input  logic             stored,
  input  logic             dropped,
  input  logic [EOB_W-1:0] eob_len,
  output logic [IRQ_N-1:0] flags,
  output logic             irq,
  output logic             eob,
  output logic             overflow
);

  logic [EOB_W-1:0] eob_cnt;
  logic [EOB_W-1:0] goal;
  logic             hit;

  assign goal = EOB_W'(eob_goal(int'(eob_len), EOB_DEFAULT));
  assign hit  = stored && ((eob_cnt + EOB_W'(1)) == goal);
  assign irq  = |(flags & int_ena);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags    <= '0;
      eob      <= 1'b0;
      eob_cnt  <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      flags    <= '0;
      eob      <= 1'b0;
      eob_cnt  <= '0;
      overflow <= 1'b0;
    end else begin
      flags <= (flags & ~int_clr) | ev;
      eob   <= hit;
      if (stored) eob_cnt <= hit ? '0 : eob_cnt + EOB_W'(1);
      if (dropped) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/i2s_rx_core.sv
module i2s_rx_core
  import i2s_rx_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int FIFO_DEPTH  = 128,
  parameter int EOB_W       = 16,
  parameter int EOB_DEFAULT = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rx_start,
  input  logic              right_first,
  input  logic              msb_right,
  input  logic              msb_shift,
  input  logic [EOB_W-1:0]  eob_len,
  input  logic              bit_tick,
  input  logic              ws_in,
  input  logic              sd_in,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [2:0]        int_ena,
  input  logic [2:0]        int_clr,
  output logic [2:0]        int_flags,
  output logic              irq,
  output logic              eob,
  output logic              overflow
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic              wvld;
  logic [WORD_W-1:0] wdata;
  logic              slot_bound;
  logic [CW-1:0]     f_level;
  logic              f_full;
  logic              f_empty;
  logic              push_ok;
  logic              pop_ok;
  logic              push_drop;
  logic [IRQ_N-1:0]  ev;

  i2s_rx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .run        (rx_start),
    .right_first(right_first),
    .msb_shift  (msb_shift),
    .msb_right  (msb_right),
    .bit_tick   (bit_tick),
    .ws_in      (ws_in),
    .sd_in      (sd_in),
    .word_vld   (wvld),
    .word_data  (wdata),
    .slot_bound (slot_bound)
  );

  i2s_rx_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .wr_req (wvld),
    .wr_data(wdata),
    .rd_req (rd_en),
    .rd_data(rd_data),
    .level  (f_level),
    .full   (f_full),
    .empty  (f_empty),
    .wr_ok  (push_ok),
    .rd_ok  (pop_ok),
    .drop   (push_drop)
  );

  assign rd_valid = !f_empty;

  assign ev[IRQ_FULL]  = push_ok && !pop_ok && (f_level == CW'(FIFO_DEPTH - 1));
  assign ev[IRQ_EMPTY] = pop_ok && !push_ok && (f_level == CW'(1));
  assign ev[IRQ_TAKE]  = push_ok;

  i2s_rx_events #(.EOB_W(EOB_W), .EOB_DEFAULT(EOB_DEFAULT)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .ev      (ev),
    .int_ena (int_ena),
    .int_clr (int_clr),
    .stored  (push_ok),
    .dropped (push_drop),
    .eob_len (eob_len),
    .flags   (int_flags),
    .irq     (irq),
    .eob     (eob),
    .overflow(overflow)
  );

endmodule

// File: rtl/i2s_rx_core_chk.sv
module i2s_rx_core_chk #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          rx_start,
  input logic          word_vld,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          f_full,
  input logic [CW-1:0] f_level,
  input logic          rd_valid,
  input logic [2:0]    int_flags,
  input logic [2:0]    int_ena,
  input logic          irq,
  input logic          eob,
  input logic          overflow
);

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!rd_valid && int_flags == 3'b000 && !overflow && !eob)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (f_full && word_vld && !pop_ok) |=> (f_full && overflow)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    overflow |=> overflow); // R7

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    f_level <= CW'(DEPTH)); // R6

  AST_STOP_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !rx_start |=> !word_vld); // R11

  AST_EOB_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    eob |-> $past(push_ok)); // R8

  AST_TAKE_FLAG: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    push_ok |=> int_flags[2]); // R9

  AST_IRQ_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ($rose(int_flags[2]) && int_ena[2]) |-> irq); // R10

endmodule

bind i2s_rx_core i2s_rx_core_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .rx_start (rx_start),
  .word_vld (wvld),
  .push_ok  (push_ok),
  .pop_ok   (pop_ok),
  .f_full   (f_full),
  .f_level  (f_level),
  .rd_valid (rd_valid),
  .int_flags(int_flags),
  .int_ena  (int_ena),
  .irq      (irq),
  .eob      (eob),
  .overflow (overflow)
);

// File: tb/i2s_rx_core_test.sv
`timescale 1ns/1ps
module i2s_rx_core_test;

  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        rx_start = 1'b0;
  logic        right_first = 1'b0;
  logic        msb_right = 1'b0;
  logic        msb_shift = 1'b0;
  logic [15:0] eob_len = 16'd0;
  logic        bit_tick = 1'b0;
  logic        ws_in = 1'b1;
  logic        sd_in = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [2:0]  int_ena = 3'b000;
  logic [2:0]  int_clr = 3'b000;
  logic [2:0]  int_flags;
  logic        irq;
  logic        eob;
  logic        overflow;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int eob_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2s_rx_core uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_start(rx_start),
    .right_first(right_first), .msb_right(msb_right), .msb_shift(msb_shift),
    .eob_len(eob_len), .bit_tick(bit_tick), .ws_in(ws_in), .sd_in(sd_in),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .int_ena(int_ena),
    .int_clr(int_clr), .int_flags(int_flags), .irq(irq), .eob(eob),
    .overflow(overflow)
  );

  function automatic logic [31:0] flip(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = w[31-i];
    return r;
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] base, input int s);
    return base + 32'h01030507 * s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] mq[$];
  bit [2:0] m_flags;
  bit m_ovf, m_eob, m_pv;
  logic [31:0] m_pw;
  int m_ec;
  bit m_wsq, m_ed, m_sy, m_al, m_ch;
  int m_cnt;
  logic [31:0] m_sh;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || soft_rst) begin
      mq.delete(); m_flags = 0; m_ovf = 0; m_eob = 0; m_pv = 0; m_ec = 0;
      m_wsq = 0; m_ed = 0; m_sy = 0; m_al = 0; m_cnt = 0; m_sh = 0; m_ch = 0;
    end else begin
      int sz, ns, goal;
      bit ap, ah, ch_edge, bnd;
      sz = mq.size();
      ap = rd_en && sz > 0;
      ah = m_pv && sz < DEPTH;
      if (m_pv && sz >= DEPTH) m_ovf = 1;
      if (ap) void'(mq.pop_front());
      if (ah) mq.push_back(m_pw);
      ns = mq.size();
      m_flags = (m_flags & ~int_clr) | {ah, ap && ns == 0, ah && ns == DEPTH};
      m_eob = 0;
      if (ah) begin
        goal = (eob_len == 0) ? 128 : int'(eob_len);
        m_ec++;
        if (m_ec == goal) begin m_eob = 1; m_ec = 0; end
      end
      m_pv = 0;
      if (!rx_start) begin
        m_wsq = ws_in; m_ed = 0; m_sy = 0; m_al = 0; m_cnt = 0;
      end else if (bit_tick) begin
        ch_edge = (ws_in != m_wsq);
        bnd = msb_shift ? m_ed : ch_edge;
        if (bnd) begin
          if (m_sy && m_cnt == 32 && (m_al || m_ch == right_first)) begin
            m_pv = 1; m_pw = msb_right ? flip(m_sh) : m_sh; m_al = 1;
          end
          m_sy = 1; m_cnt = 1; m_sh = {31'b0, sd_in}; m_ch = ws_in;
        end else if (m_cnt < 32) begin
          m_sh = {m_sh[30:0], sd_in}; m_cnt++;
        end
        m_wsq = ws_in; m_ed = ch_edge;
      end
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 rd_valid", 32'(rd_valid), 32'(mq.size() > 0));
      if (mq.size() > 0) check("R2 rd_data", rd_data, mq[0]);
      check("R9 int_flags", 32'(int_flags), 32'(m_flags));
      check("R10 irq", 32'(irq), 32'(|(m_flags & int_ena)));
      check("R7 overflow", 32'(overflow), 32'(m_ovf));
      check("R8 eob", 32'(eob), 32'(m_eob));
      if (eob) eob_seen++;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc >= 190000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] exp_q[$];

  task automatic put_bit(input logic ws, input logic sd);
    @(negedge clk); ws_in = ws; sd_in = sd; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // n slots, left first; bits delayed one tick when shifted.
  task automatic send_slots(input int n, input logic [31:0] base, input bit shifted);
    for (int s = 0; s < n; s++) begin
      for (int k = 0; k < 32; k++) begin
        logic b;
        if (!shifted) b = word_of(base, s)[31-k];
        else if (k == 0) b = (s > 0) ? word_of(base, s-1)[0] : 1'b0;
        else b = word_of(base, s)[32-k];
        put_bit(logic'(s % 2), b);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int got = 0;
    while (rd_valid && got < 200) begin
      @(negedge clk);
      if (got < exp_q.size()) check(req, rd_data, exp_q[got]);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      got++;
    end
    check({req, " count"}, 32'(got), 32'(exp_q.size()));
    exp_q.delete();
  endtask

  task automatic configure(input bit rf, input bit mr, input bit ms);
    @(negedge clk); rx_start = 1'b0; ws_in = 1'b1;
    @(negedge clk); right_first = rf; msb_right = mr; msb_shift = ms;
    @(negedge clk); rx_start = 1'b1;
  endtask

  task automatic clear_flags();
    @(negedge clk); int_clr = 3'b111;
    @(negedge clk); int_clr = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state in reset
    check("R1 rd_valid in reset", 32'(rd_valid), 0);
    check("R1 flags in reset", 32'(int_flags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 overflow after reset", 32'(overflow), 0);

    // R2 R6 R8: left first, MSB first, aligned
    eob_len = 16'd2;
    eob_seen = 0;
    configure(0, 0, 0);
    send_slots(6, 32'h12345600, 0);
    check("R8 eob pulses len2", 32'(eob_seen), 2);
    check("R9 take flag", 32'(int_flags[2]), 1);
    for (int i = 0; i < 5; i++) exp_q.push_back(word_of(32'h12345600, i));
    drain("R2 R6 left-first word");
    check("R9 empty flag after drain", 32'(int_flags[1]), 1);
    clear_flags();
    check("R9 flags cleared", 32'(int_flags), 0);

    // R4 R10: right first, first left slot dropped
    int_ena = 3'b100;
    check("R10 irq idle", 32'(irq), 0);
    configure(1, 0, 0);
    send_slots(6, 32'hA0B0C000, 0);
    check("R10 irq on take", 32'(irq), 1);
    for (int i = 1; i < 5; i++) exp_q.push_back(word_of(32'hA0B0C000, i));
    drain("R4 right-first word");
    int_ena = 3'b000;
    clear_flags();

    // R3: delayed MSB
    configure(0, 0, 1);
    send_slots(6, 32'h5A5A0100, 1);
    for (int i = 0; i < 5; i++) exp_q.push_back(word_of(32'h5A5A0100, i));
    drain("R3 shifted word");
    clear_flags();

    // R5: bit-reversed storage
    configure(0, 1, 0);
    send_slots(4, 32'h00C0FF10, 0);
    for (int i = 0; i < 3; i++) exp_q.push_back(flip(word_of(32'h00C0FF10, i)));
    drain("R5 reversed word");
    clear_flags();

    // R11: stopped receiver stores nothing
    @(negedge clk); rx_start = 1'b0; right_first = 0; msb_right = 0;
    send_slots(4, 32'h77770000, 0);
    check("R11 nothing stored while stopped", 32'(rd_valid), 0);
    check("R11 no take flag while stopped", 32'(int_flags[2]), 0);

    // R7 R8 R9: overflow with default block length
    eob_len = 16'd0;
    eob_seen = 0;
    configure(0, 0, 0);
    send_slots(132, 32'h01000000, 0);
    check("R7 overflow set", 32'(overflow), 1);
    check("R9 full flag", 32'(int_flags[0]), 1);
    check("R8 default eob count", 32'(eob_seen), 1);
    @(negedge clk); rx_start = 1'b0;
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(word_of(32'h01000000, i));
    drain("R7 kept words");
    check("R7 overflow sticky", 32'(overflow), 1);

    // R1: soft reset clears
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R1 overflow after soft reset", 32'(overflow), 0);
    check("R1 flags after soft reset", 32'(int_flags), 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule